// File: doc/BRIEF.md
# NOR Flash Command Interpreter Model

This block is a synthesizable behavioural stand-in for the device side of a 16-bit NOR flash. The storage array is a small on-chip word memory. Real timing is replaced by cycle counts. A host issues single-cycle write and read strobes. The block decodes the software-protected unlock sequences that guard word programming, sector erase, whole-array erase and entry into the identification mode. It then runs the selected operation internally for a fixed number of clock cycles.

While an operation is in progress, reads do not return array data. They return a polling status word. Bit 7 carries the completion indicator and bit 6 toggles on each successive read. This lets host software written for a real part detect completion in the usual way.

The array is addressed by the low `MEM_AW` bits of the address, and a sector is `2**SECT_AW` consecutive words. A read issued in cycle N presents its word on `rdata` after the clock edge that samples it, and `rdata` holds until the next read. The host never asserts both strobes in the same cycle.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, `busy` is 0, `rdata` is 0000h, the command sequencer is waiting for a first unlock cycle and identification mode is off.
- R2: In normal mode with no operation running, a read returns the array word at `addr[MEM_AW-1:0]` one cycle later, so higher address bits alias.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h followed by one write of address/data start a word program. `busy` is 1 for exactly `PROG_CYC` cycles, starting the cycle after the data write. The word then holds old AND data, so programming can only clear bits.
- R4: The six-write sequence 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then 30h at any address, erases the sector selected by `addr[MEM_AW-1:SECT_AW]` of that last write. Every word of that sector becomes FFFFh and other sectors are untouched. `busy` is 1 for `SECT_CYC` cycles.
- R5: The same first five writes followed by 10h at 5555h set every array word to FFFFh, with `busy` high for `CHIP_CYC` cycles.
- R6: A read while `busy` is 1 returns a status word with bits 15..8 and 5..0 zero. Bit 7 is the complement of bit 7 of the data being programmed during a program, and 0 during either erase.
- R7: Bit 6 of the status word is the inverse of the bit-6 value returned by the previous busy read. The first busy read after reset returns 1.
- R8: Every write accepted while `busy` is 1 is ignored, including identification exit: the sequencer, the identification mode and the array are unchanged by it.
- R9: A write that does not match the expected next step of a sequence returns the sequencer to its first step without starting anything. That write is not taken as the start of a new sequence.
- R10: 5555h/AAh, 2AAAh/55h, 5555h/90h enter identification mode. There, with `addr[15:1]` zero, address 0 reads 00BFh and address 1 reads 2788h. Other addresses read the array.
- R11: Identification mode is left either by 5555h/AAh, 2AAAh/55h, 5555h/F0h or by a single write of F0h at any address, outside the data step of a program.
- R12: Command cycles compare only `addr[14:0]` and `wdata[7:0]`; `addr[15]` and `wdata[15:8]` have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one bus write per cycle |
| rd_en | input | 1 | Read strobe, one bus read per cycle |
| addr | input | 16 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status word, registered |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
A sequencer stuck in a wrong step shows up on the cycle after the final command write. Either `busy` fails to rise, or it rises for a sequence that should have been dropped. The next read then shows the array contents changed or unchanged contrary to expectation. A wrong identification flag appears on the very next read of address 0 or 1. A bad operation timer shows as a `busy` window of the wrong length, and a bad erase sweep shows as a word that is not FFFFh, or a neighbouring sector that is, on the first read after `busy` falls. A broken status path is visible on any read made while `busy` is high, in bit 7, bit 6 or the zero bits.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
// Package: shared types and command constants for the NOR command interpreter.
// Assumes command cycles compare 15 address bits and 8 data bits.
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM_DATA,
        SQ_ERS1,
        SQ_ERS2,
        SQ_ERS3
    } seq_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_t;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  UNLOCK_KEY_A  = 8'hAA;
    localparam logic [7:0]  UNLOCK_KEY_B  = 8'h55;
    localparam logic [7:0]  CODE_PROG     = 8'hA0;
    localparam logic [7:0]  CODE_ERASE    = 8'h80;
    localparam logic [7:0]  CODE_SECTOR   = 8'h30;
    localparam logic [7:0]  CODE_CHIP     = 8'h10;
    localparam logic [7:0]  CODE_ID_ENTER = 8'h90;
    localparam logic [7:0]  CODE_ID_EXIT  = 8'hF0;

    localparam logic [15:0] ID_WORD_MAKER  = 16'h00BF;
    localparam logic [15:0] ID_WORD_DEVICE = 16'h2788;
    localparam logic [15:0] ERASED_WORD    = 16'hFFFF;

endpackage

// File: rtl/nor_cmd_array.sv
`timescale 1ns/1ps
// Module: word storage standing in for the flash array.
// One write port, two combinational read ports (bus read and program merge).
// Assumes contents are undefined until erased; no reset on the storage.
module nor_cmd_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra_bus,
    output logic [DW-1:0] rd_bus,
    input  logic [AW-1:0] ra_merge,
    output logic [DW-1:0] rd_merge
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store one word per cycle when the operation unit writes.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[wa] <= wd;
        end
    end

    // Present both read ports without delay.
    always_comb begin
        rd_bus   = cells[ra_bus];
        rd_merge = cells[ra_merge];
    end
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
// Module: command sequencer. Walks the unlock steps, issues one-cycle start
// pulses for program and erase, and holds the identification-mode flag.
// Assumes the caller blocks all writes while an operation is running (busy).
module nor_cmd_seq
    import nor_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        busy,
    input  logic [14:0] cmd_addr,
    input  logic [7:0]  cmd_code,
    output logic        go_prog,
    output logic        go_sect,
    output logic        go_chip,
    output logic        id_mode,
    output seq_t        state
);
    seq_t nxt;
    logic accept;
    logic at_a;
    logic at_b;
    logic id_set;
    logic id_clr;

    assign accept = wr_en && !busy;
    assign at_a   = (cmd_addr == UNLOCK_ADDR_A);
    assign at_b   = (cmd_addr == UNLOCK_ADDR_B);

    // Decode the accepted write against the expected step.
    always_comb begin
        nxt     = state;
        go_prog = 1'b0;
        go_sect = 1'b0;
        go_chip = 1'b0;
        id_set  = 1'b0;
        id_clr  = 1'b0;
        if (accept) begin
            nxt = SQ_IDLE;
            case (state)
                SQ_IDLE: begin
                    if (at_a && cmd_code == UNLOCK_KEY_A) nxt = SQ_UNL1;
                    else if (cmd_code == CODE_ID_EXIT)    id_clr = 1'b1;
                end
                SQ_UNL1: begin
                    if (at_b && cmd_code == UNLOCK_KEY_B) nxt = SQ_UNL2;
                    else if (cmd_code == CODE_ID_EXIT)    id_clr = 1'b1;
                end
                SQ_UNL2: begin
                    if (at_a && cmd_code == CODE_PROG)          nxt = SQ_PGM_DATA;
                    else if (at_a && cmd_code == CODE_ERASE)    nxt = SQ_ERS1;
                    else if (at_a && cmd_code == CODE_ID_ENTER) id_set = 1'b1;
                    else if (cmd_code == CODE_ID_EXIT)          id_clr = 1'b1;
                end
                SQ_PGM_DATA: begin
                    go_prog = 1'b1;
                end
                SQ_ERS1: begin
                    if (at_a && cmd_code == UNLOCK_KEY_A) nxt = SQ_ERS2;
                    else if (cmd_code == CODE_ID_EXIT)    id_clr = 1'b1;
                end
                SQ_ERS2: begin
                    if (at_b && cmd_code == UNLOCK_KEY_B) nxt = SQ_ERS3;
                    else if (cmd_code == CODE_ID_EXIT)    id_clr = 1'b1;
                end
                SQ_ERS3: begin
                    if (cmd_code == CODE_SECTOR)                nxt = SQ_IDLE;
                    else if (!(at_a && cmd_code == CODE_CHIP) &&
                             cmd_code == CODE_ID_EXIT)          id_clr = 1'b1;
                    go_sect = (cmd_code == CODE_SECTOR);
                    go_chip = at_a && (cmd_code == CODE_CHIP);
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    // Advance the step register and the identification flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            state <= nxt;
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end
endmodule

// File: rtl/nor_cmd_op.sv
`timescale 1ns/1ps
// Module: internal operation unit. Times program and erase in clock cycles,
// merges program data into the old word on the last cycle, and sweeps
// erased words to all ones one word per cycle.
// Assumes SECT_CYC > 2**SECT_AW and CHIP_CYC > 2**MEM_AW so the sweep ends
// inside the timed window; otherwise busy stretches until the sweep ends.
module nor_cmd_op
    import nor_cmd_pkg::*;
#(
    parameter int MEM_AW   = 8,
    parameter int SECT_AW  = 4,
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_prog,
    input  logic              go_sect,
    input  logic              go_chip,
    input  logic [MEM_AW-1:0] op_addr,
    input  logic [15:0]       op_data,
    input  logic [15:0]       old_word,
    output logic              busy,
    output op_t               kind,
    output logic              prog_b7,
    output logic [MEM_AW-1:0] prog_addr,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_wa,
    output logic [15:0]       mem_wd
);
    localparam int LONGEST = (CHIP_CYC > SECT_CYC) ?
                             ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC) :
                             ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int SEL_W   = MEM_AW - SECT_AW;

    logic [CNT_W-1:0]  remain;
    logic [MEM_AW-1:0] sweep_idx;
    logic [MEM_AW-1:0] sweep_end;
    logic              sweep_done;
    logic [15:0]       prog_data;
    logic [SEL_W-1:0]  sect_sel;

    assign sect_sel  = op_addr[MEM_AW-1:SECT_AW];
    assign prog_b7   = prog_data[7];

    // Launch an operation or step the running one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            kind       <= OP_NONE;
            remain     <= '0;
            sweep_idx  <= '0;
            sweep_end  <= '0;
            sweep_done <= 1'b1;
            prog_data  <= '0;
            prog_addr  <= '0;
        end else if (!busy) begin
            if (go_prog) begin
                busy       <= 1'b1;
                kind       <= OP_PROG;
                remain     <= CNT_W'(PROG_CYC - 1);
                sweep_done <= 1'b1;
                prog_data  <= op_data;
                prog_addr  <= op_addr;
            end else if (go_sect) begin
                busy       <= 1'b1;
                kind       <= OP_SECT;
                remain     <= CNT_W'(SECT_CYC - 1);
                sweep_done <= 1'b0;
                sweep_idx  <= {sect_sel, {SECT_AW{1'b0}}};
                sweep_end  <= {sect_sel, {SECT_AW{1'b1}}};
            end else if (go_chip) begin
                busy       <= 1'b1;
                kind       <= OP_CHIP;
                remain     <= CNT_W'(CHIP_CYC - 1);
                sweep_done <= 1'b0;
                sweep_idx  <= '0;
                sweep_end  <= '1;
            end
        end else begin
            if (remain != '0) remain <= remain - 1'b1;
            if (!sweep_done) begin
                if (sweep_idx == sweep_end) sweep_done <= 1'b1;
                else                        sweep_idx  <= sweep_idx + 1'b1;
            end
            if (remain == '0 && sweep_done) busy <= 1'b0;
        end
    end

    // Select the array write: program merge at the end, or sweep word.
    always_comb begin
        if (kind == OP_PROG) begin
            mem_we = busy && (remain == '0);
            mem_wa = prog_addr;
            mem_wd = old_word & prog_data;
        end else begin
            mem_we = busy && !sweep_done;
            mem_wa = sweep_idx;
            mem_wd = ERASED_WORD;
        end
    end
endmodule

// File: rtl/nor_cmd_engine.sv
`timescale 1ns/1ps
// Module: top of the NOR command interpreter model. Connects the sequencer,
// operation unit and array, and forms the registered read path that returns
// array data, identification words or the busy-time status word.
// Assumes wr_en and rd_en are never high in the same cycle.
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int MEM_AW   = 8,
    parameter int SECT_AW  = 4,
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        busy
);
    logic              go_prog;
    logic              go_sect;
    logic              go_chip;
    logic              id_mode;
    seq_t              seq_state;
    op_t               op_kind;
    logic              prog_b7;
    logic [MEM_AW-1:0] prog_addr;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_wa;
    logic [15:0]       mem_wd;
    logic [15:0]       rd_word;
    logic [15:0]       old_word;
    logic              toggle_q;
    logic              stat_b7;
    logic              id_hit;

    nor_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .cmd_addr (addr[14:0]),
        .cmd_code (wdata[7:0]),
        .go_prog  (go_prog),
        .go_sect  (go_sect),
        .go_chip  (go_chip),
        .id_mode  (id_mode),
        .state    (seq_state)
    );

    nor_cmd_op #(
        .MEM_AW   (MEM_AW),
        .SECT_AW  (SECT_AW),
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_op (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .go_sect   (go_sect),
        .go_chip   (go_chip),
        .op_addr   (addr[MEM_AW-1:0]),
        .op_data   (wdata),
        .old_word  (old_word),
        .busy      (busy),
        .kind      (op_kind),
        .prog_b7   (prog_b7),
        .prog_addr (prog_addr),
        .mem_we    (mem_we),
        .mem_wa    (mem_wa),
        .mem_wd    (mem_wd)
    );

    nor_cmd_array #(
        .AW (MEM_AW),
        .DW (16)
    ) u_array (
        .clk      (clk),
        .we       (mem_we),
        .wa       (mem_wa),
        .wd       (mem_wd),
        .ra_bus   (addr[MEM_AW-1:0]),
        .rd_bus   (rd_word),
        .ra_merge (prog_addr),
        .rd_merge (old_word)
    );

    assign stat_b7 = (op_kind == OP_PROG) ? ~prog_b7 : 1'b0;
    assign id_hit  = id_mode && (addr[15:1] == 15'd0);

    // Register the read result: status while busy, else ID word or array word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            toggle_q <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata    <= {8'h00, stat_b7, ~toggle_q, 6'b000000};
                toggle_q <= ~toggle_q;
            end else if (id_hit) begin
                rdata <= addr[0] ? ID_WORD_DEVICE : ID_WORD_MAKER;
            end else begin
                rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/nor_cmd_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for nor_cmd_engine, attached with bind below.
// Assumes the bound instance uses the same duration parameters.
module nor_cmd_chk
    import nor_cmd_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 300
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rdata,
    input logic        busy,
    input op_t         op_kind,
    input logic        prog_b7,
    input seq_t        seq_state,
    input logic        id_mode
);
    int   run_len;
    int   want_len;
    logic stat_seen;
    logic last_b6;
    logic have_b6;

    // Count cycles during which busy is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // Remember that the previous cycle issued a read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_seen <= 1'b0;
        else        stat_seen <= rd_en && busy;
    end

    // Keep bit 6 of the most recent status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_b6 <= 1'b0;
            have_b6 <= 1'b0;
        end else if (stat_seen) begin
            last_b6 <= rdata[6];
            have_b6 <= 1'b1;
        end
    end

    assign want_len = (op_kind == OP_PROG) ? PROG_CYC :
                      (op_kind == OP_SECT) ? SECT_CYC : CHIP_CYC;

    // R3 with R4 and R5: busy window has the length of its operation.
    assert_op_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == want_len);

    // R6: status during program carries the complement of data bit 7.
    assert_prog_dq7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && op_kind == OP_PROG) |=> rdata[7] != prog_b7);

    // R6: status during either erase reads bit 7 as zero.
    assert_erase_dq7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && op_kind != OP_PROG) |=> rdata[7] == 1'b0);

    // R6: unused status bits read as zero.
    assert_status_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

    // R7: consecutive status words differ in bit 6.
    assert_dq6_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_seen && have_b6) |-> rdata[6] != last_b6);

    // R8: writes while busy leave the sequencer in place.
    assert_seq_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(seq_state));

    // R8: identification mode cannot change while busy.
    assert_id_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));
endmodule

bind nor_cmd_engine nor_cmd_chk #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .busy      (busy),
    .op_kind   (op_kind),
    .prog_b7   (prog_b7),
    .seq_state (seq_state),
    .id_mode   (id_mode)
);

// File: tb/test_nor_cmd_engine.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module test_nor_cmd_engine;
    localparam int MEM_AW   = 8;
    localparam int SECT_AW  = 4;
    localparam int PROG_CYC = 8;
    localparam int SECT_CYC = 40;
    localparam int CHIP_CYC = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    logic btog = 1'b0;

    logic [15:0] q_val  [$];
    logic [15:0] q_mask [$];
    string       q_tag  [$];
    logic [15:0] m_val;
    logic [15:0] m_mask;
    string       m_tag;

    always #2.5 clk = ~clk;

    nor_cmd_engine #(
        .MEM_AW   (MEM_AW),
        .SECT_AW  (SECT_AW),
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) i_nor_cmd_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [15:0] exp,
                          input logic [15:0] mask, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        q_val.push_back(exp); q_mask.push_back(mask); q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Busy read: bit 7 given, bit 6 follows the R7 rule, rest zero (R6).
    task automatic rd_status(input logic b7, input string tag);
        btog = ~btog;
        bus_rd(16'h0000, {8'h00, b7, btog, 6'b0}, 16'hFFFF, tag);
    endtask

    task automatic check_val(input logic [15:0] act, input logic [15:0] exp,
                             input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic unlock3(input logic [7:0] code);
        bus_wr(16'h5555, {8'h00, 8'hAA});
        bus_wr(16'h2AAA, {8'h00, 8'h55});
        bus_wr(16'h5555, {8'h00, code});
    endtask

    task automatic erase6(input logic [15:0] a, input logic [7:0] code);
        unlock3(8'h80);
        bus_wr(16'h5555, 16'h00AA);
        bus_wr(16'h2AAA, 16'h0055);
        bus_wr(a, {8'h00, code});
    endtask

    // Monitor: pop and compare one expected word per read.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #1;
                if (q_val.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard: read %h with nothing expected", rdata);
                end else begin
                    m_val = q_val.pop_front();
                    m_mask = q_mask.pop_front();
                    m_tag = q_tag.pop_front();
                    checks++;
                    if ((rdata & m_mask) !== (m_val & m_mask))
                        begin
                        fails++;
                        $display("FAIL %s: rdata %h expected %h mask %h",
                                 m_tag, rdata, m_val, m_mask);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val({15'd0, busy}, 16'd0, "R1 busy after reset");
        check_val(rdata, 16'h0000, "R1 rdata after reset");

        // R5: chip erase and its duration.
        erase6(16'h5555, 8'h10);
        wait_idle(n);
        check_val(16'(n), 16'(CHIP_CYC), "R5 chip erase busy cycles");
        bus_rd(16'h0000, 16'hFFFF, 16'hFFFF, "R5 word 0 erased");
        bus_rd(16'h00FF, 16'hFFFF, 16'hFFFF, "R5 last word erased");

        // R3 + R6 + R7: program with status reads.
        unlock3(8'hA0);
        bus_wr(16'h0012, 16'h1234);
        rd_status(1'b1, "R6 R7 program status 1");
        rd_status(1'b1, "R6 R7 program status 2");
        wait_idle(n);
        bus_rd(16'h0012, 16'h1234, 16'hFFFF, "R3 programmed word");

        // R3: duration of a program.
        unlock3(8'hA0);
        bus_wr(16'h0020, 16'h8001);
        wait_idle(n);
        check_val(16'(n), 16'(PROG_CYC), "R3 program busy cycles");
        bus_rd(16'h0020, 16'h8001, 16'hFFFF, "R3 second word");

        // R3: reprogram clears bits only; R6 bit 7 complement of 1.
        unlock3(8'hA0);
        bus_wr(16'h0012, 16'hFF8F);
        rd_status(1'b0, "R6 R7 program status data bit7 set");
        wait_idle(n);
        bus_rd(16'h0012, 16'h1204, 16'hFFFF, "R3 old AND new");

        // R4 + R6 + R8: sector erase of sector 1 with ignored writes.
        erase6(16'h0015, 8'h30);
        rd_status(1'b0, "R6 R7 erase status");
        unlock3(8'hA0);
        bus_wr(16'h0040, 16'h0000);
        wait_idle(n);
        bus_rd(16'h0012, 16'hFFFF, 16'hFFFF, "R4 sector word erased");
        bus_rd(16'h001F, 16'hFFFF, 16'hFFFF, "R4 sector end erased");
        bus_rd(16'h0020, 16'h8001, 16'hFFFF, "R4 neighbour untouched");
        bus_rd(16'h0040, 16'hFFFF, 16'hFFFF, "R8 program while busy ignored");

        // R10: identification entry and reads.
        unlock3(8'h90);
        bus_rd(16'h0000, 16'h00BF, 16'hFFFF, "R10 maker word");
        bus_rd(16'h0001, 16'h2788, 16'hFFFF, "R10 device word");
        bus_rd(16'h0020, 16'h8001, 16'hFFFF, "R10 other address reads array");

        // R8: exit attempt during a program is ignored.
        unlock3(8'hA0);
        bus_wr(16'h0030, 16'h5A5A);
        bus_wr(16'h0000, 16'h00F0);
        wait_idle(n);
        bus_rd(16'h0000, 16'h00BF, 16'hFFFF, "R8 ID mode kept through busy");
        bus_rd(16'h0030, 16'h5A5A, 16'hFFFF, "R3 program in ID mode");

        // R11: single-cycle exit at an arbitrary address.
        bus_wr(16'h1234, 16'h00F0);
        bus_rd(16'h0000, 16'hFFFF, 16'hFFFF, "R11 single F0 exit");

        // R11: three-cycle exit.
        unlock3(8'h90);
        bus_rd(16'h0001, 16'h2788, 16'hFFFF, "R10 re-entry");
        unlock3(8'hF0);
        bus_rd(16'h0001, 16'hFFFF, 16'hFFFF, "R11 three-cycle exit");

        // R4: sector 3 duration.
        erase6(16'h0035, 8'h30);
        wait_idle(n);
        check_val(16'(n), 16'(SECT_CYC), "R4 sector erase busy cycles");
        bus_rd(16'h0030, 16'hFFFF, 16'hFFFF, "R4 sector 3 erased");

        // R9: broken sequence at step 3, then A0 and data do nothing.
        bus_wr(16'h5555, 16'h00AA);
        bus_wr(16'h2AAA, 16'h0055);
        bus_wr(16'h5555, 16'h0077);
        bus_wr(16'h5555, 16'h00A0);
        bus_wr(16'h0050, 16'h0000);
        @(negedge clk);
        check_val({15'd0, busy}, 16'd0, "R9 no operation after abort");
        bus_rd(16'h0050, 16'hFFFF, 16'hFFFF, "R9 word untouched after abort");

        // R9: broken at step 2, the 90 write is not a new start.
        bus_wr(16'h5555, 16'h00AA);
        bus_wr(16'h1234, 16'h0055);
        bus_wr(16'h5555, 16'h0090);
        bus_rd(16'h0000, 16'hFFFF, 16'hFFFF, "R9 no ID entry after abort");

        // R12: upper address bit and upper data byte ignored.
        bus_wr(16'hD555, 16'h3CAA);
        bus_wr(16'hAAAA, 16'h9955);
        bus_wr(16'hD555, 16'h7790);
        bus_rd(16'h0000, 16'h00BF, 16'hFFFF, "R12 ID entry with noise bits");
        bus_wr(16'h0000, 16'hA5F0);
        bus_rd(16'h0000, 16'hFFFF, 16'hFFFF, "R12 exit with noise byte");
        bus_wr(16'hD555, 16'h12AA);
        bus_wr(16'hAAAA, 16'h3455);
        bus_wr(16'hD555, 16'h56A0);
        bus_wr(16'h0060, 16'hABCD);
        wait_idle(n);
        bus_rd(16'h0060, 16'hABCD, 16'hFFFF, "R12 program with noise bits");

        // R2: high address bits alias onto the array.
        bus_rd(16'h0160, 16'hABCD, 16'hFFFF, "R2 aliased read");

        repeat (3) @(negedge clk);
        if (q_val.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d reads never answered", q_val.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule